// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder Stage

This block adds two radix-2 signed-digit words of `NDIG` digits, by default 8, and never ripples a carry. Every digit takes a value in {-1, 0, +1}. A word's value is the sum of digit i times 2^i. On the ports each digit uses two wires: `2'b01` means +1, `2'b10` means -1 and `2'b00` means 0. The stage has a second input mode. In that mode it takes one pre-summed operand, whose five-level digits each arrive as a 3-bit two's-complement field.

Each digit position works in three steps:
1. It forms a linear sum in {-2..+2}.
2. It splits that sum into an intermediate digit and a transfer carry. The split depends only on the digit's own sum and on whether the next lower position's sum is positive.
3. It adds the carry coming up from below.

The result never leaves {-1, 0, +1}, so the logic depth is the same for any width. The result goes to a register, and a configuration input can bypass that register to give purely combinational operation.

Wider words are built from stages of `NDIG` digits. Each stage passes up its top transfer carry and a flag that says whether its top linear sum is positive. The next stage takes both on its cascade inputs. The least significant stage ties its cascade carry to 0 and its flag to "not positive".

The design is a pure datapath and has no state machine. Its only state is the result register. That register clears on reset and loads on every clock edge.

Top module: `sd_add_stage`

## Requirements
- R1: The result value plus 2^NDIG times the value of `c_out` equals value(`op_a`) + value(`op_b`) + value(`c_in`). Digit codes are `2'b01`=+1, `2'b10`=-1, `2'b00`=0, and digit i sits in bits [2i+1:2i].
- R2: When `use_packed`=1, the linear sum of digit i is taken from `lin_in[3i+2:3i]`, read as 3-bit two's complement with legal values -2..+2. In this mode `op_a` and `op_b` have no effect on any output.
- R3: If the lower linear sum is greater than 0, the linear sum z splits into (intermediate, carry) as follows: z=-2 gives (0,-1), z=-1 gives (-1,0), z=0 gives (0,0), z=+1 gives (-1,+1), z=+2 gives (0,+1). For digit 0, "lower positive" is `pos_in`.
- R4: If the lower linear sum is 0 or less, the split is: z=-2 gives (0,-1), z=-1 gives (+1,-1), z=0 gives (0,0), z=+1 gives (+1,0), z=+2 gives (0,+1).
- R5: Result digit i equals intermediate i plus the carry from digit i-1. For digit 0 that carry is `c_in`. The result is always a legal code and never `2'b11`.
- R6: `c_out` is the carry of the top digit and `pos_out` is 1 exactly when the top linear sum is greater than 0. Both depend combinationally on the current inputs.
- R7: An operand digit coded `2'b11` is treated as 0. A packed field of 3, -3 or -4 is treated as 0.
- R8: With `bypass`=1, `sum_out` shows the result of the current inputs. With `bypass`=0, it shows the result captured at the last clock edge. The register loads on every edge regardless of `bypass`.
- R9: A synchronous active-high `rst` clears the result register to all-zero digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the result register |
| bypass | input | 1 | 1: combinational result on `sum_out`; 0: registered result |
| use_packed | input | 1 | 1: take linear sums from `lin_in` |
| op_a | input | 2*NDIG | First signed-digit operand |
| op_b | input | 2*NDIG | Second signed-digit operand |
| lin_in | input | 3*NDIG | Packed five-level digits, 3-bit two's complement each |
| c_in | input | 2 | Carry digit from the lower stage |
| pos_in | input | 1 | Lower stage's top linear sum is positive |
| sum_out | output | 2*NDIG | Signed-digit result |
| c_out | output | 2 | Carry digit of the top position |
| pos_out | output | 1 | Top linear sum is positive |

## Verification
The bench builds the stage with the default `NDIG`=8. With that width it can reach a full 8-digit carry pattern: all linear sums at +2 or at -2, and a lower-positive chain running from `pos_in` through every position. The cascade carry then lands at 2^8 in the value check. The cascade inputs are always driven as a consistent pair, derived from a randomly chosen lower linear sum, so both split tables are exercised at digit 0.

// File: rtl/sd_pkg.sv
package sd_pkg;

    localparam logic [1:0] SD_ZERO  = 2'b00;
    localparam logic [1:0] SD_PLUS  = 2'b01;
    localparam logic [1:0] SD_MINUS = 2'b10;

    // two-wire digit code to signed value; the unused code reads as zero
    function automatic logic signed [2:0] sd_dec(input logic [1:0] code);
        unique case (code)
            SD_PLUS:  return 3'sd1;
            SD_MINUS: return -3'sd1;
            default:  return 3'sd0;
        endcase
    endfunction

    // signed value in {-1,0,+1} to two-wire code
    function automatic logic [1:0] sd_enc(input logic signed [2:0] val);
        if (val == 3'sd1)
            return SD_PLUS;
        else if (val == -3'sd1)
            return SD_MINUS;
        return SD_ZERO;
    endfunction

    // packed five-level field, 3-bit two's complement, out-of-range as zero
    function automatic logic signed [2:0] lin_dec(input logic [2:0] field);
        logic signed [2:0] v;
        v = $signed(field);
        if (v > 3'sd2 || v < -3'sd2)
            return 3'sd0;
        return v;
    endfunction

endpackage

// File: rtl/sd_linsum.sv
module sd_linsum #(
    parameter int NDIG = 8
) (
    input  logic                use_packed,
    input  logic [2*NDIG-1:0]   op_a,
    input  logic [2*NDIG-1:0]   op_b,
    input  logic [3*NDIG-1:0]   lin_in,
    output logic [3*NDIG-1:0]   z_flat
);
    import sd_pkg::*;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        logic signed [2:0] pair_sum;
        always_comb begin
            pair_sum = sd_dec(op_a[2*i +: 2]) + sd_dec(op_b[2*i +: 2]);
            z_flat[3*i +: 3] = use_packed ? lin_dec(lin_in[3*i +: 3]) : pair_sum;
        end
    end

endmodule

// File: rtl/sd_split.sv
module sd_split #(
    parameter int NDIG = 8
) (
    input  logic [3*NDIG-1:0]   z_flat,
    input  logic                pos_in,
    output logic [2*NDIG-1:0]   w_flat,
    output logic [2*NDIG-1:0]   c_flat,
    output logic                pos_top
);
    logic [NDIG:0] pos_vec;
    assign pos_vec[0] = pos_in;
    assign pos_top    = pos_vec[NDIG];

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        logic signed [2:0] z;
        logic signed [1:0] w;
        logic signed [1:0] c;
        assign z = $signed(z_flat[3*i +: 3]);
        assign pos_vec[i+1] = (z > 3'sd0);

        always_comb begin
            unique case (z)
                -3'sd2: begin w = 2'sd0;  c = -2'sd1; end
                -3'sd1: begin
                    w = pos_vec[i] ? -2'sd1 : 2'sd1;
                    c = pos_vec[i] ? 2'sd0  : -2'sd1;
                end
                3'sd1: begin
                    w = pos_vec[i] ? -2'sd1 : 2'sd1;
                    c = pos_vec[i] ? 2'sd1  : 2'sd0;
                end
                3'sd2:  begin w = 2'sd0;  c = 2'sd1;  end
                default: begin w = 2'sd0; c = 2'sd0;  end
            endcase
        end

        assign w_flat[2*i +: 2] = w;
        assign c_flat[2*i +: 2] = c;
    end

endmodule

// File: rtl/sd_final.sv
module sd_final #(
    parameter int NDIG = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bypass,
    input  logic [2*NDIG-1:0]   w_flat,
    input  logic [2*NDIG-1:0]   c_flat,
    input  logic [1:0]          c_in,
    output logic [2*NDIG-1:0]   sum_now,
    output logic [2*NDIG-1:0]   sum_out
);
    import sd_pkg::*;

    logic [2*NDIG-1:0] sum_q;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        logic signed [2:0] c_low;
        logic signed [2:0] w_ext;
        if (i == 0) begin : g_lsb
            assign c_low = sd_dec(c_in);
        end else begin : g_up
            assign c_low = {c_flat[2*i-1], c_flat[2*i-2 +: 2]};
        end
        assign w_ext = {w_flat[2*i+1], w_flat[2*i +: 2]};
        assign sum_now[2*i +: 2] = sd_enc(w_ext + c_low);
    end

    always_ff @(posedge clk) begin
        if (rst)
            sum_q <= '0;
        else
            sum_q <= sum_now;
    end

    assign sum_out = bypass ? sum_now : sum_q;

endmodule

// File: rtl/sd_add_stage.sv
module sd_add_stage #(
    parameter int NDIG = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bypass,
    input  logic                use_packed,
    input  logic [2*NDIG-1:0]   op_a,
    input  logic [2*NDIG-1:0]   op_b,
    input  logic [3*NDIG-1:0]   lin_in,
    input  logic [1:0]          c_in,
    input  logic                pos_in,
    output logic [2*NDIG-1:0]   sum_out,
    output logic [1:0]          c_out,
    output logic                pos_out
);
    import sd_pkg::*;

    localparam int TOP = NDIG - 1;

    logic [3*NDIG-1:0] z_flat;
    logic [2*NDIG-1:0] w_flat;
    logic [2*NDIG-1:0] c_flat;
    logic [2*NDIG-1:0] sum_now;

    sd_linsum #(.NDIG(NDIG)) u_lin (
        .use_packed (use_packed),
        .op_a       (op_a),
        .op_b       (op_b),
        .lin_in     (lin_in),
        .z_flat     (z_flat)
    );

    sd_split #(.NDIG(NDIG)) u_split (
        .z_flat     (z_flat),
        .pos_in     (pos_in),
        .w_flat     (w_flat),
        .c_flat     (c_flat),
        .pos_top    (pos_out)
    );

    sd_final #(.NDIG(NDIG)) u_fin (
        .clk        (clk),
        .rst        (rst),
        .bypass     (bypass),
        .w_flat     (w_flat),
        .c_flat     (c_flat),
        .c_in       (c_in),
        .sum_now    (sum_now),
        .sum_out    (sum_out)
    );

    assign c_out = sd_enc({c_flat[2*TOP+1], c_flat[2*TOP +: 2]});

endmodule

// File: rtl/sd_add_stage_chk.sv
module sd_add_stage_chk #(
    parameter int NDIG = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                bypass,
    input logic                use_packed,
    input logic [2*NDIG-1:0]   op_a,
    input logic [2*NDIG-1:0]   op_b,
    input logic [3*NDIG-1:0]   lin_in,
    input logic [1:0]          c_in,
    input logic [2*NDIG-1:0]   sum_now,
    input logic [2*NDIG-1:0]   sum_out,
    input logic [1:0]          c_out,
    input logic                pos_out
);
    function automatic longint dval(input logic [1:0] code);
        if (code == 2'b01) return 1;
        if (code == 2'b10) return -1;
        return 0;
    endfunction

    function automatic longint wval(input logic [2*NDIG-1:0] word);
        longint acc = 0;
        for (int i = 0; i < NDIG; i++)
            acc += dval(word[2*i +: 2]) * (longint'(1) <<< i);
        return acc;
    endfunction

    function automatic longint pval(input logic [3*NDIG-1:0] word);
        longint acc = 0;
        for (int i = 0; i < NDIG; i++) begin
            longint f = longint'($signed(word[3*i +: 3]));
            if (f > 2 || f < -2) f = 0;
            acc += f * (longint'(1) <<< i);
        end
        return acc;
    endfunction

    function automatic logic has_bad_code(input logic [2*NDIG-1:0] word);
        for (int i = 0; i < NDIG; i++)
            if (word[2*i +: 2] == 2'b11) return 1'b1;
        return 1'b0;
    endfunction

    longint res_val;
    assign res_val = wval(sum_now) + dval(c_out) * (longint'(1) <<< NDIG);

    assert_value_pair_R1: assert property (@(posedge clk) disable iff (rst)
        !use_packed |-> res_val == wval(op_a) + wval(op_b) + dval(c_in));

    assert_value_packed_R2: assert property (@(posedge clk) disable iff (rst)
        use_packed |-> res_val == pval(lin_in) + dval(c_in));

    assert_digit_legal_R5: assert property (@(posedge clk) disable iff (rst)
        !has_bad_code(sum_out) && !has_bad_code(sum_now));

    assert_carry_sign_R6: assert property (@(posedge clk) disable iff (rst)
        (c_out != 2'b11) && (c_out != 2'b01 || pos_out) && (c_out != 2'b10 || !pos_out));

    assert_reg_load_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (bypass || sum_out == $past(sum_now)));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (bypass || sum_out == '0));

endmodule

bind sd_add_stage sd_add_stage_chk #(.NDIG(NDIG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bypass     (bypass),
    .use_packed (use_packed),
    .op_a       (op_a),
    .op_b       (op_b),
    .lin_in     (lin_in),
    .c_in       (c_in),
    .sum_now    (sum_now),
    .sum_out    (sum_out),
    .c_out      (c_out),
    .pos_out    (pos_out)
);

// File: tb/tb_sd_add_stage.sv
`timescale 1ns/1ps
module tb_sd_add_stage;
    localparam int N = 8;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bypass = 1'b0;
    logic use_packed = 1'b0;
    logic [2*N-1:0] op_a = '0;
    logic [2*N-1:0] op_b = '0;
    logic [3*N-1:0] lin_in = '0;
    logic [1:0] c_in = 2'b00;
    logic pos_in = 1'b0;
    logic [2*N-1:0] sum_out;
    logic [1:0] c_out;
    logic pos_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [2*N-1:0] pend = '0;
    logic [2*N-1:0] exp_reg = '0;

    sd_add_stage #(.NDIG(N)) dut (
        .clk(clk), .rst(rst), .bypass(bypass), .use_packed(use_packed),
        .op_a(op_a), .op_b(op_b), .lin_in(lin_in), .c_in(c_in), .pos_in(pos_in),
        .sum_out(sum_out), .c_out(c_out), .pos_out(pos_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) exp_reg <= rst ? '0 : pend;

    function automatic int dig(input logic [1:0] code);
        return (code == 2'b01) ? 1 : (code == 2'b10) ? -1 : 0;
    endfunction

    function automatic logic [1:0] code_of(input int v);
        return (v == 1) ? 2'b01 : (v == -1) ? 2'b10 : 2'b00;
    endfunction

    function automatic int fld(input logic [2:0] f);
        int v = (f[2]) ? int'(f) - 8 : int'(f);
        return (v > 2 || v < -2) ? 0 : v;
    endfunction

    // carry rule shared by bench stimulus and model
    function automatic int carry_of(input int z, input bit low_pos);
        if (z >= 2 || (z == 1 && low_pos)) return 1;
        if (z <= -2 || (z == -1 && !low_pos)) return -1;
        return 0;
    endfunction

    function automatic void model(output logic [2*N-1:0] s, output logic [1:0] co,
                                  output logic po);
        int z [N];
        int c [N];
        for (int i = 0; i < N; i++)
            z[i] = use_packed ? fld(lin_in[3*i +: 3])
                              : dig(op_a[2*i +: 2]) + dig(op_b[2*i +: 2]);
        for (int i = 0; i < N; i++) begin
            bit lp = (i == 0) ? pos_in : (z[i-1] > 0);
            c[i] = carry_of(z[i], lp);
        end
        for (int i = 0; i < N; i++) begin
            int cl = (i == 0) ? dig(c_in) : c[i-1];
            s[2*i +: 2] = code_of(z[i] - 2*c[i] + cl);
        end
        co = code_of(c[N-1]);
        po = (z[N-1] > 0);
    endfunction

    function automatic int wv(input logic [2*N-1:0] w);
        int acc = 0;
        for (int i = 0; i < N; i++) acc += dig(w[2*i +: 2]) << i;
        return acc;
    endfunction

    function automatic logic [2*N-1:0] rand_word();
        logic [2*N-1:0] w;
        for (int i = 0; i < N; i++) w[2*i +: 2] = code_of(int'($urandom_range(0, 2)) - 1);
        return w;
    endfunction

    task automatic rand_low();
        int zl = int'($urandom_range(0, 4)) - 2;
        bit pl = 1'($urandom_range(0, 1));
        pos_in = (zl > 0);
        c_in = code_of(carry_of(zl, pl));
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // called just after inputs change at a falling edge
    task automatic step(input string tag);
        logic [2*N-1:0] es;
        logic [1:0] ec;
        logic ep;
        int bad11;
        #1;
        model(es, ec, ep);
        chk("R6", "c_out", 32'(c_out), 32'(ec));
        chk("R6", "pos_out", 32'(pos_out), 32'(ep));
        bad11 = 0;
        for (int i = 0; i < N; i++) if (sum_out[2*i +: 2] == 2'b11) bad11++;
        chk("R5", "illegal digits", 32'(bad11), 32'd0);
        if (bypass) begin
            int expv;
            chk(tag, "sum_out", 32'(sum_out), 32'(es));
            if (use_packed) begin
                expv = dig(c_in);
                for (int i = 0; i < N; i++) expv += fld(lin_in[3*i +: 3]) << i;
            end else begin
                expv = 0;
                for (int i = 0; i < N; i++)
                    expv += ((op_a[2*i +: 2] == 2'b11) ? 0 : dig(op_a[2*i +: 2])) << i;
                expv += wv(op_b) + dig(c_in);
            end
            chk("R1", "value", 32'(wv(sum_out) + (dig(c_out) << N)), 32'(expv));
        end else begin
            chk("R8", "registered sum_out", 32'(sum_out), 32'(exp_reg));
        end
        pend = es;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired, R all, actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "sum_out after reset", 32'(sum_out), 32'd0);
        rst = 1'b0;

        // R3: every lower sum positive, all z=+1, carry in +1
        @(negedge clk);
        bypass = 1; op_a = {N{2'b01}}; op_b = '0; pos_in = 1; c_in = 2'b01;
        step("R3");
        chk("R3", "digits all zero", 32'(sum_out), 32'd0);

        // R4: digit 0 sees a non-positive lower sum
        @(negedge clk);
        pos_in = 0; c_in = 2'b00;
        step("R4");
        chk("R4", "digits 1:0", 32'(sum_out[3:0]), 32'b1001);

        // all z=+2 and all z=-2
        @(negedge clk);
        op_b = {N{2'b01}}; pos_in = 0; c_in = 2'b00;
        step("R3");
        @(negedge clk);
        op_a = {N{2'b10}}; op_b = {N{2'b10}};
        step("R4");

        // R7: illegal operand digits read as zero
        @(negedge clk);
        op_a = {N{2'b11}}; op_b = rand_word(); rand_low();
        step("R7");
        chk("R7", "value ignores 11", 32'(wv(sum_out) + (dig(c_out) << N)),
            32'(wv(op_b) + dig(c_in)));

        // R7: illegal packed fields (3, -4, -3) read as zero
        @(negedge clk);
        use_packed = 1;
        lin_in = {3'd3, 3'd4, 3'd5, 3'd3, 3'd4, 3'd5, 3'd3, 3'd1};
        pos_in = 0; c_in = 2'b00;
        step("R7");
        chk("R7", "packed illegal", 32'(sum_out), 32'(16'b0000_0000_0000_0001));

        // R2: packed input, operands randomised and ignored
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) lin_in[3*i +: 3] = 3'($urandom_range(0, 4) + 6);
            op_a = rand_word(); op_b = rand_word(); rand_low();
            step("R2");
        end
        use_packed = 0;

        // R1: random pair operands, combinational path
        for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            op_a = rand_word(); op_b = rand_word(); rand_low();
            step("R1");
        end

        // R8: registered path
        bypass = 0;
        for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            op_a = rand_word(); op_b = rand_word(); rand_low();
            use_packed = (k % 5 == 0);
            for (int i = 0; i < N; i++) lin_in[3*i +: 3] = 3'($urandom_range(0, 7));
            step("R8");
        end

        // R9: reset during operation
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        chk("R9", "sum_out cleared", 32'(sum_out), 32'd0);
        rst = 0;
        @(negedge clk);
        op_a = rand_word(); step("R8");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule